// File: doc/BRIEF.md
# Invariant Timestamp Counter with Deadline Interrupt

This block keeps a 64-bit timestamp that advances at a fixed rate no matter what the core's clock frequency or power state is. An always-running reference count advances by one on each reference tick. The timestamp is built from that count as a programmable ratio times the count, plus a signed offset. The offset is the sum of two separate offset registers: one for system software and one for a virtual machine monitor.

A deadline comparator lets software schedule one interrupt. Software writes a target timestamp, and the block raises a one-cycle interrupt pulse once the timestamp is equal to or beyond that target. Writing a target of zero cancels the pending deadline. A simple register port holds the ratio, both offsets and the target. The same port reads back the live timestamp and the reference count.

Top module: `tsc_core`

## Requirements
- R1: After reset: reference count 0, timestamp 0, ratio 1, both offsets 0, deadline disarmed, `irq_o` low.
- R2: On each clock edge where `ref_tick_i` is high, the reference count increments by exactly one. When `ref_tick_i` is low, the count holds.
- R3: `lowpwr_i` has no effect on the reference count or on the timestamp.
- R4: Timestamp = ratio × count + adjust + virt_offset, modulo 2^64. Both offsets are 64-bit two's-complement values.
- R5: While none of ratio, adjust or virt_offset is written, the timestamp never decreases from one cycle to the next.
- R6: Writing a nonzero target arms the deadline. `irq_o` rises on the clock edge after the first cycle in which the deadline is armed and timestamp >= target. A target that has already passed therefore gives `irq_o` high in the second cycle after the write edge.
- R7: `irq_o` is a single-cycle pulse. The deadline disarms when it fires and stays disarmed until the target is written again.
- R8: Writing a target of zero disarms the deadline without producing a pulse.
- R9: Register address map (`reg_addr_i`):
  - 0: ratio (RATIO_W bits, zero-extended on read)
  - 1: adjust
  - 2: virt_offset
  - 3: deadline target
  - 4: timestamp (read-only)
  - 5: reference count (read-only)
  
  Reads are combinational. Writes take effect on the clock edge where `reg_we_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_tick_i | input | 1 | Reference clock enable; advances the reference count |
| lowpwr_i | input | 1 | Core is in a low-power state (does not affect counting) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | One-cycle deadline interrupt pulse |

## Verification
A reference count stuck or skipping shows up within one tick as a wrong value when address 5 or address 4 is read. An offset error shows in the very next timestamp read, and for extreme offsets as a wrong wrap at 2^64. A deadline armed flag that stays set after firing shows as a second pulse on the cycle after the first. A missing arm shows as no pulse two cycles after a target in the past is written. A zero target that fails to disarm shows as a pulse once the timestamp passes the stale target.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int unsigned TS_W    = 64;
  localparam int unsigned ADDR_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_RATIO    = 3'd0,
    SEL_ADJUST   = 3'd1,
    SEL_VOFFSET  = 3'd2,
    SEL_DEADLINE = 3'd3,
    SEL_TSTAMP   = 3'd4,
    SEL_REFCNT   = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/tsc_refcnt.sv
module tsc_refcnt #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (tick_i) cnt_o <= cnt_o + 1'b1;
  end

  a_r2_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_o));
  a_r2_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/tsc_offset_regs.sv
module tsc_offset_regs
  import tsc_pkg::*;
#(
  parameter int unsigned RATIO_W   = 32,
  parameter logic [RATIO_W-1:0] RATIO_RST = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  reg_sel_e           sel_i,
  input  logic [TS_W-1:0]    wdata_i,
  output logic [RATIO_W-1:0] ratio_o,
  output logic [TS_W-1:0]    adjust_o,
  output logic [TS_W-1:0]    voffset_o,
  output logic [TS_W-1:0]    offset_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_o   <= RATIO_RST;
      adjust_o  <= '0;
      voffset_o <= '0;
    end else if (we_i) begin
      unique case (sel_i)
        SEL_RATIO:   ratio_o   <= wdata_i[RATIO_W-1:0];
        SEL_ADJUST:  adjust_o  <= wdata_i;
        SEL_VOFFSET: voffset_o <= wdata_i;
        default: ;
      endcase
    end
  end

  // two's-complement sum, wraps modulo 2^TS_W
  assign offset_o = adjust_o + voffset_o;
endmodule

// File: rtl/tsc_deadline.sv
module tsc_deadline
  import tsc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [TS_W-1:0] target_i,
  input  logic [TS_W-1:0] ts_i,
  output logic [TS_W-1:0] target_o,
  output logic            irq_o
);
  logic armed_q;
  logic hit;

  assign hit = armed_q && (ts_i >= target_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      target_o <= '0;
      armed_q  <= 1'b0;
      irq_o    <= 1'b0;
    end else begin
      irq_o <= hit;
      if (wr_i) begin
        target_o <= target_i;
        armed_q  <= (target_i != '0);
      end else if (hit) begin
        armed_q  <= 1'b0;
      end
    end
  end

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !$past(wr_i) |=> !irq_o);
  a_r7_disarm_on_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !$past(wr_i) |-> !armed_q);
  a_r8_zero_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && target_i == '0) |=> !armed_q);
  a_r8_no_fire_disarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |=> !irq_o);
endmodule

// File: rtl/tsc_core.sv
module tsc_core
  import tsc_pkg::*;
#(
  parameter int unsigned RATIO_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_tick_i,
  input  logic              lowpwr_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [TS_W-1:0]   reg_wdata_i,
  output logic [TS_W-1:0]   reg_rdata_o,
  output logic              irq_o
);
  localparam logic [RATIO_W-1:0] RatioRst = RATIO_W'(1);

  reg_sel_e           sel;
  logic [TS_W-1:0]    ref_cnt;
  logic [RATIO_W-1:0] ratio;
  logic [TS_W-1:0]    adjust, voffset, offset, target, tstamp;
  logic               cfg_wr;

  assign sel = reg_sel_e'(reg_addr_i);

  // low-power state intentionally does not gate the reference count
  tsc_refcnt #(.CNT_W(TS_W)) u_refcnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (ref_tick_i),
    .cnt_o  (ref_cnt)
  );

  tsc_offset_regs #(.RATIO_W(RATIO_W), .RATIO_RST(RatioRst)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .sel_i     (sel),
    .wdata_i   (reg_wdata_i),
    .ratio_o   (ratio),
    .adjust_o  (adjust),
    .voffset_o (voffset),
    .offset_o  (offset)
  );

  assign tstamp = ref_cnt * TS_W'(ratio) + offset;

  tsc_deadline u_deadline (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (reg_we_i && sel == SEL_DEADLINE),
    .target_i (reg_wdata_i),
    .ts_i     (tstamp),
    .target_o (target),
    .irq_o    (irq_o)
  );

  always_comb begin
    unique case (sel)
      SEL_RATIO:    reg_rdata_o = TS_W'(ratio);
      SEL_ADJUST:   reg_rdata_o = adjust;
      SEL_VOFFSET:  reg_rdata_o = voffset;
      SEL_DEADLINE: reg_rdata_o = target;
      SEL_TSTAMP:   reg_rdata_o = tstamp;
      SEL_REFCNT:   reg_rdata_o = ref_cnt;
      default:      reg_rdata_o = '0;
    endcase
  end

  assign cfg_wr = reg_we_i &&
                  (sel == SEL_RATIO || sel == SEL_ADJUST || sel == SEL_VOFFSET);

  a_r5_ts_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_wr |=> tstamp >= $past(tstamp));
  a_r3_lowpwr_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lowpwr_i && ref_tick_i) |=> ref_cnt != $past(ref_cnt));
endmodule

// File: tb/tsc_core_bench.sv
module tsc_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        lowpwr = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  int irq_cnt = 0;
  int wide_pulses = 0;
  logic irq_prev = 1'b0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  tsc_core u_tsc_core (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick), .lowpwr_i(lowpwr),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  always @(posedge clk) begin
    if (rst_n && irq) irq_cnt++;
    if (rst_n && irq && irq_prev) wide_pulses++;
    irq_prev = irq;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; we = 1'b0; ref_tick = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      ref_tick = 1'b1;
      repeat (n) @(negedge clk);
      ref_tick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {ratio, adjust, virt_offset, ticks, expected timestamp}
  typedef struct packed {
    logic [31:0] ratio;
    logic [63:0] adj;
    logic [63:0] voff;
    logic [15:0] n;
    logic [63:0] exp;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'd1,  64'd0,     64'd0,                    16'd5, 64'd5},
    '{32'd3,  64'd10,    64'd0,                    16'd7, 64'd31},
    '{32'd4,  '1,        64'd0,                    16'd2, 64'd7},
    '{32'd2,  64'd100,   -64'sd50,                 16'd6, 64'd62},
    '{32'd1,  '1,        64'd2,                    16'd0, 64'd1},
    '{32'd25, 64'd0,     64'h8000_0000_0000_0000,  16'd4, 64'h8000_0000_0000_0064}
  };

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] v, prev;
    int base;
    do_reset();

    // R1 reset state
    rd(3'd4, v); chk("R1 ts", v, 64'd0);
    rd(3'd0, v); chk("R1 ratio", v, 64'd1);
    rd(3'd1, v); chk("R1 adjust", v, 64'd0);
    rd(3'd5, v); chk("R1 refcnt", v, 64'd0);
    chk("R1 irq", {63'd0, irq}, 64'd0);

    // R4 / R9 vector table
    foreach (VECS[i]) begin
      do_reset();
      ticks(int'(VECS[i].n));
      wr(3'd0, 64'(VECS[i].ratio));
      wr(3'd1, VECS[i].adj);
      wr(3'd2, VECS[i].voff);
      rd(3'd4, v); chk($sformatf("R4 vec%0d ts", i), v, VECS[i].exp);
      rd(3'd2, v); chk($sformatf("R9 vec%0d voff readback", i), v, VECS[i].voff);
    end

    // R2 tick hold and step
    do_reset();
    idle(4);
    rd(3'd5, v); chk("R2 hold without tick", v, 64'd0);
    ticks(9);
    rd(3'd5, v); chk("R2 nine ticks", v, 64'd9);

    // R3 low-power state does not stop counting
    lowpwr = 1'b1;
    ticks(6);
    rd(3'd5, v); chk("R3 count in low power", v, 64'd15);
    rd(3'd4, v); chk("R3 ts in low power", v, 64'd15);
    lowpwr = 1'b0;

    // R5 monotonic over ticks with large ratio
    wr(3'd0, 64'd1000);
    rd(3'd4, prev);
    ticks(3);
    rd(3'd4, v); chk("R5 non-decreasing", {63'd0, v >= prev}, 64'd1);
    chk("R5 value", v, 64'd18000);

    // R6 future deadline: no early fire, then exactly one pulse
    do_reset();
    ticks(10);
    base = irq_cnt;
    wr(3'd3, 64'd13);
    idle(5);
    chk("R6 no early fire", 64'(irq_cnt - base), 64'd0);
    ticks(3);
    idle(3);
    chk("R6 fires at target", 64'(irq_cnt - base), 64'd1);
    // R7 disarmed after firing
    ticks(5);
    idle(4);
    chk("R7 one-shot", 64'(irq_cnt - base), 64'd1);
    rd(3'd3, v); chk("R9 target readback", v, 64'd13);

    // R6 past target: high in the second cycle after the write edge
    wr(3'd3, 64'd2);
    chk("R6 past target not yet", {63'd0, irq}, 64'd0);
    @(negedge clk);
    chk("R6 past target fires", {63'd0, irq}, 64'd1);
    @(negedge clk);
    chk("R7 pulse width one", {63'd0, irq}, 64'd0);

    // R8 zero target disarms
    base = irq_cnt;
    wr(3'd3, 64'd20);
    wr(3'd3, 64'd0);
    ticks(8);
    idle(4);
    chk("R8 zero disarms", 64'(irq_cnt - base), 64'd0);

    chk("R7 no wide pulses", 64'(wide_pulses), 64'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule